// File: doc/BRIEF.md
# Sixteen-bit eight-function ALU

This block is a purely combinational arithmetic-logic unit. It takes two 16-bit operands and a 3-bit operation code. It returns a 16-bit result and three flags: signed overflow, unsigned overflow and operand equality. The operations are bitwise OR and AND, addition, subtraction, three shifts (logical left, logical right, arithmetic right) and a signed set-less-than.

Addition and subtraction share one gate-level ripple-carry chain. Subtraction and the signed compare both use that chain as A plus inverted B plus one. The shifts go through a log-depth barrel shifter. Its shift distance comes only from the low four bits of operand B. The equality flag compares the operands for every operation code, so a datapath can read it whatever operation it selected.

Top module: `alu16_core`

## Requirements
- R1: Code 000 returns A | B and code 001 returns A & B.
- R2: Code 010 returns (A + B) mod 2^16. The unsigned overflow flag is 1 exactly when the true sum exceeds 16'hFFFF.
- R3: During code 010 the signed overflow flag is 1 exactly when the two's-complement sum of A and B lies outside -32768..32767. During code 011 the same flag does this for A - B.
- R4: Code 011 returns (A - B) mod 2^16, and the unsigned overflow flag stays 0.
- R5: Code 100 returns A shifted left by B[3:0], with zeros shifted in at bit 0.
- R6: Code 101 returns A shifted right by B[3:0], filling with zeros. Code 110 returns A shifted right by B[3:0], filling with copies of A[15].
- R7: For codes 100, 101 and 110, bits B[15:4] have no effect on the result.
- R8: Code 111 returns 16'h0001 when A < B as signed two's-complement values, and 16'h0000 otherwise.
- R9: The equality flag is 1 exactly when A equals B, for every operation code.
- R10: For codes 000, 001 and 100 through 111, both overflow flags are 0.
- R11: A shift distance B[3:0] = 0 returns A unchanged for codes 100, 101 and 110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B; bits 3..0 are the shift distance |
| op_i | input | 3 | Operation code |
| res_o | output | 16 | Result |
| sovf_o | output | 1 | Signed overflow flag |
| uovf_o | output | 1 | Unsigned overflow flag |
| eq_o | output | 1 | A equals B |

## Verification
The block holds no registers, so every output is due in the same cycle that the operands and code are applied: zero clock cycles of latency. The bench changes inputs only on a rising edge of its clock and reads all four outputs half a period later, on the falling edge, after the combinational logic has settled. The operand values come from a fixed corner set crossed with itself and from a linear-feedback sequence, and all eight codes are swept for each pair.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    OP_OR  = 3'b000,
    OP_AND = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b011,
    OP_SLL = 3'b100,
    OP_SRL = 3'b101,
    OP_SRA = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // Two's-complement overflow from the sign bits of the effective operands and the sum.
  function automatic logic f_signed_ovf(input logic a_msb, input logic b_msb, input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  function automatic logic f_is_shift(input alu_op_e op);
    return (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
  endfunction

  // Signed less-than from the subtract result sign and its overflow.
  function automatic logic f_signed_lt(input logic diff_msb, input logic ovf);
    return diff_msb ^ ovf;
  endfunction

endpackage

// File: rtl/alu16_adder.sv
module alu16_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         sovf_o
);
  import alu16_pkg::*;

  logic [W-1:0] b_eff;
  logic [W:0]   carry;

  assign b_eff    = b_i ^ {W{sub_i}};
  assign carry[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
  end

  assign cout_o = carry[W];
  assign sovf_o = f_signed_ovf(a_i[W-1], b_eff[W-1], sum_o[W-1]);

  always_comb begin
    AST_SUM_MATCH: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i})); // R2
  end

endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  y_o
);
  logic [W-1:0] stage [0:SW];
  logic         fill;

  assign fill     = arith_i & a_i[W-1];
  assign stage[0] = a_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [W-1:0] fill_mask;
    assign fill_mask  = fill ? ~({W{1'b1}} >> D) : '0;
    assign stage[k+1] = !amt_i[k] ? stage[k]
                      : (left_i ? (stage[k] << D) : ((stage[k] >> D) | fill_mask));
  end

  assign y_o = stage[SW];

  always_comb begin
    if (amt_i == '0) AST_SHIFT_ZERO: assert (y_o == a_i); // R11
    if (!left_i && arith_i && a_i[W-1]) AST_SRA_TOP: assert (y_o[W-1]); // R6
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         sovf_o,
  output logic         uovf_o,
  output logic         eq_o
);
  import alu16_pkg::*;

  alu_op_e      op;
  logic         use_sub;
  logic [W-1:0] sum;
  logic         carry_out;
  logic         add_sovf;
  logic [W-1:0] shifted;
  logic         less;

  assign op      = alu_op_e'(op_i);
  assign use_sub = (op == OP_SUB) || (op == OP_SLT);

  alu16_adder #(.W(W)) u_add (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sub_i (use_sub),
    .sum_o (sum),
    .cout_o(carry_out),
    .sovf_o(add_sovf)
  );

  alu16_shifter #(.W(W), .SW(SW)) u_shf (
    .a_i    (opa_i),
    .amt_i  (opb_i[SW-1:0]),
    .left_i (op == OP_SLL),
    .arith_i(op == OP_SRA),
    .y_o    (shifted)
  );

  assign less = f_signed_lt(sum[W-1], add_sovf);

  always_comb begin
    unique case (op)
      OP_OR:   res_o = opa_i | opb_i;
      OP_AND:  res_o = opa_i & opb_i;
      OP_ADD,
      OP_SUB:  res_o = sum;
      OP_SLT:  res_o = {{(W-1){1'b0}}, less};
      default: res_o = shifted;
    endcase
  end

  assign sovf_o = ((op == OP_ADD) || (op == OP_SUB)) & add_sovf;
  assign uovf_o = (op == OP_ADD) & carry_out;
  assign eq_o   = ~|(opa_i ^ opb_i);

  always_comb begin
    AST_EQ_FLAG: assert (eq_o == (opa_i == opb_i)); // R9
    if (op != OP_ADD && op != OP_SUB) AST_NO_OVERFLOW: assert (!sovf_o && !uovf_o); // R10
    if (op == OP_SUB) AST_SUB_NO_UOVF: assert (!uovf_o); // R4
    if (op == OP_SLT) AST_SLT_UPPER: assert (res_o[W-1:1] == '0); // R8
    if (f_is_shift(op) && opb_i[SW-1:0] == '0) AST_SHIFT_PASS: assert (res_o == opa_i); // R11
  end

endmodule

// File: tb/sim_alu16_core.sv
module sim_alu16_core;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a, b;
  logic [2:0]  op;
  logic [15:0] res;
  logic        sovf, uovf, eq;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_core u0 (
    .opa_i(a), .opb_i(b), .op_i(op),
    .res_o(res), .sovf_o(sovf), .uovf_o(uovf), .eq_o(eq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h op=%0d act=%h exp=%h", tag, a, b, op, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic [2:0] vo);
    @(posedge clk);
    a = va; b = vb; op = vo;
    @(negedge clk);
  endtask

  function automatic int ref_res(input logic [15:0] x, input logic [15:0] y, input logic [2:0] o);
    int sh = int'(y[3:0]);
    int sx = int'($signed(x));
    int sy = int'($signed(y));
    int r;
    case (o)
      3'd0: r = int'(x | y);
      3'd1: r = int'(x & y);
      3'd2: r = (int'(x) + int'(y)) & 32'hFFFF;
      3'd3: r = (int'(x) - int'(y)) & 32'hFFFF;
      3'd4: r = (int'(x) << sh) & 32'hFFFF;
      3'd5: r = int'(x) >> sh;
      3'd6: r = (sx >>> sh) & 32'hFFFF;
      default: r = (sx < sy) ? 1 : 0;
    endcase
    return r;
  endfunction

  function automatic int ref_sovf(input logic [15:0] x, input logic [15:0] y, input logic [2:0] o);
    int v;
    if (o == 3'd2) v = int'($signed(x)) + int'($signed(y));
    else if (o == 3'd3) v = int'($signed(x)) - int'($signed(y));
    else return 0;
    return (v > 32767 || v < -32768) ? 1 : 0;
  endfunction

  function automatic string res_tag(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5, 3'd6: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic full_check(input logic [15:0] va, input logic [15:0] vb, input logic [2:0] vo);
    apply(va, vb, vo);
    chk(res_tag(vo), int'(res), ref_res(va, vb, vo));
    if (vo == 3'd2 || vo == 3'd3) chk("R3", int'(sovf), ref_sovf(va, vb, vo));
    else chk("R10", int'(sovf), 0);
    if (vo == 3'd2) chk("R2", int'(uovf), ((int'(va) + int'(vb)) > 65535) ? 1 : 0);
    else if (vo == 3'd3) chk("R4", int'(uovf), 0);
    else chk("R10", int'(uovf), 0);
    chk("R9", int'(eq), (va == vb) ? 1 : 0);
  endtask

  logic [15:0] corners [0:8];
  initial begin
    corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'h7FFF;
    corners[3] = 16'h8000; corners[4] = 16'hFFFF; corners[5] = 16'h5555;
    corners[6] = 16'hAAAA; corners[7] = 16'h1234; corners[8] = 16'h8001;
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] keep;
    a = '0; b = '0; op = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle inputs: OR of zeros, no flags, operands equal (R1, R9, R10)
    chk("R1", int'(res), 0);
    chk("R9", int'(eq), 1);
    chk("R10", int'(sovf | uovf), 0);

    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        for (int o = 0; o < 8; o++)
          full_check(corners[i], corners[j], 3'(o));

    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] va;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      va = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int o = 0; o < 8; o++) full_check(va, lfsr, 3'(o));
    end

    // R7: upper bits of B must not change a shift result
    for (int o = 4; o < 7; o++)
      for (int s = 0; s < 16; s++) begin
        apply(16'hB3C5, 16'(s), 3'(o));
        keep = res;
        apply(16'hB3C5, 16'(s) | 16'hFFF0, 3'(o));
        chk("R7", int'(res), int'(keep));
      end

    // R11: zero shift distance passes A
    for (int o = 4; o < 7; o++) begin
      apply(16'h9A5F, 16'h7FF0, 3'(o));
      chk("R11", int'(res), 16'h9A5F);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule